// File: doc/BRIEF.md
# Floating Add/Subtract Alignment Datapath

This block performs the add/subtract step for floating values. Each value is held as a sign bit (1 means negative), an 18-bit two's-complement exponent and a 35-bit magnitude fraction. On a `start` pulse it captures both operands together with the subtract flag, a no-round modifier and a 2-bit sign-modify code. It then decides whether one operand simply passes through. If neither does, it aligns the two exponents by shifting the operand with the smaller exponent right, one position per clock. It then adds or subtracts the magnitudes, with sign resolution, and folds any carry out of the fraction back into the exponent and a guard bit.

The result is handed to a downstream normalizer without normalization. It consists of a sign, an exponent one bit wider than the inputs (so that the carry increment cannot wrap), the 35-bit fraction and the guard bit. A one-cycle `res_valid` strobe marks the result, and the result registers hold their value until the next operation finishes.

The controller has four named states. `S_IDLE` waits for `start`. In `S_IDLE`, a start whose operands pass through goes straight to `S_DONE`. A start with equal exponents goes to `S_MERGE`. Any other start goes to `S_SHIFT`. `S_SHIFT` loops on itself, one shift per clock, and moves to `S_MERGE` after its final shift. `S_MERGE` always moves to `S_DONE`, and `S_DONE` always returns to `S_IDLE`.

Top module: `fpa_align_add`

## Requirements
- R1: After reset `res_valid`, `res_sign`, `res_exp`, `res_frac` and `res_guard` are all 0.
- R2: If A's fraction is zero, or A exponent minus B exponent is below -35, the result is B's exponent and fraction. The result sign is B's sign inverted when `sub_op` is 1. The guard is 0, and `res_valid` rises one cycle after the start edge.
- R3: Otherwise, if B's fraction is zero or the exponent difference is above 35, the result is A's sign, exponent and fraction. The guard is 0, and `res_valid` rises one cycle after the start edge.
- R4: In all other cases, the fraction with the smaller exponent (B when the exponents are equal) is shifted right by the absolute difference. The result exponent is the larger one, plus 1 on a carry (R7). `res_valid` rises |difference|+2 cycles after the start edge.
- R5: After alignment with `no_round` = 0, if the most significant of the bits shifted out is 1, the aligned fraction is incremented. With `no_round` = 1 it is left truncated.
- R6: The operation is an effective subtraction when A sign XOR B sign XOR `sub_op` is 1. The smaller aligned magnitude is then subtracted from the larger. The sign is A's sign, inverted only when B's magnitude is strictly larger.
- R7: In an effective addition whose sum carries out of 35 bits, the guard takes the sum LSB, the fraction is the sum shifted right by one, and the exponent rises by 1. When `no_round` = 0 and the guard is 1, the fraction is also incremented.
- R8: The sign-modify code is applied to the final sign in every path: 00 keeps it, 01 forces 0, 10 forces 1, 11 inverts it.
- R9: `res_valid` is high for exactly one cycle per operation. The guard is 0 unless an R7 carry occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in S_IDLE) |
| a_sign | input | 1 | Sign of A, 1 = negative |
| a_exp | input | 18 | Exponent of A, two's complement |
| a_frac | input | 35 | Magnitude fraction of A |
| b_sign | input | 1 | Sign of B, 1 = negative |
| b_exp | input | 18 | Exponent of B, two's complement |
| b_frac | input | 35 | Magnitude fraction of B |
| sub_op | input | 1 | 1 = compute A minus B |
| no_round | input | 1 | 1 = suppress alignment and carry rounding |
| sgn_mod | input | 2 | Sign-modify code (R8) |
| res_valid | output | 1 | One-cycle result strobe |
| res_sign | output | 1 | Result sign |
| res_exp | output | 19 | Result exponent, two's complement |
| res_frac | output | 35 | Unnormalized result fraction |
| res_guard | output | 1 | Guard bit from a carry-out |

## Verification
Random operands are drawn with exponent differences straddling ±35, with occasional zero fractions and all sign, subtract, rounding and sign-modify combinations. This separates the two pass-through windows from the aligned path, and effective addition from effective subtraction. Directed cases pin down the boundaries. Differences of exactly ±35 and ±36 show where the window edge lies. A discarded top bit of 1, run with and without rounding, isolates the alignment increment. Equal and B-larger magnitudes under subtraction expose the sign-inversion rule. A sum whose LSB is 1 at carry-out separates the guard increment from a plain shift. The measured latency tells a serial alignment of the right length from one of the wrong length.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [1:0] {
        SM_KEEP = 2'b00,
        SM_POS  = 2'b01,
        SM_NEG  = 2'b10,
        SM_FLIP = 2'b11
    } sgn_mod_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SHIFT,
        S_MERGE,
        S_DONE
    } fpa_state_t;

    function automatic logic apply_sgn_mod(input logic s, input logic [1:0] m);
        logic r;
        unique case (sgn_mod_t'(m))
            SM_KEEP: r = s;
            SM_POS:  r = 1'b0;
            SM_NEG:  r = 1'b1;
            SM_FLIP: r = ~s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpa_shifter.sv
module fpa_shifter #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] val,
    output logic         ext_msb
);
    logic [W-1:0] ext;

    // Operand shifts right one position per step; bits leaving it enter the extension.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
            ext <= '0;
        end else if (load) begin
            val <= load_val;
            ext <= '0;
        end else if (step) begin
            {val, ext} <= {1'b0, val, ext[W-1:1]};
        end
    end

    assign ext_msb = ext[W-1];
endmodule

// File: rtl/fpa_merge.sv
module fpa_merge #(
    parameter int W = 35
) (
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    input  logic         a_sign,
    input  logic         eff_sub,
    input  logic         no_round,
    output logic [W-1:0] m_frac,
    output logic         m_sign,
    output logic         m_carry,
    output logic         m_guard
);
    logic [W:0] sum;
    logic       a_ge;

    assign sum  = {1'b0, a_mag} + {1'b0, b_mag};
    assign a_ge = (a_mag >= b_mag);

    always_comb begin
        m_carry = 1'b0;
        m_guard = 1'b0;
        m_sign  = a_sign;
        if (eff_sub) begin
            m_frac = a_ge ? (a_mag - b_mag) : (b_mag - a_mag);
            m_sign = a_ge ? a_sign : ~a_sign;
        end else if (sum[W]) begin
            m_carry = 1'b1;
            m_guard = sum[0];
            m_frac  = sum[W:1] + {{(W-1){1'b0}}, (~no_round & sum[0])};
        end else begin
            m_frac = sum[W-1:0];
        end
    end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add
    import fpa_pkg::*;
#(
    parameter int FRAC_W = 35,
    parameter int EXP_W  = 18,
    parameter int WINDOW = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [FRAC_W-1:0] a_frac,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [FRAC_W-1:0] b_frac,
    input  logic              sub_op,
    input  logic              no_round,
    input  logic [1:0]        sgn_mod,
    output logic              res_valid,
    output logic              res_sign,
    output logic [EXP_W:0]    res_exp,
    output logic [FRAC_W-1:0] res_frac,
    output logic              res_guard
);
    localparam int DW = EXP_W + 1;
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic signed [DW-1:0] WIN_S = DW'(WINDOW);

    fpa_state_t state, state_nx;

    logic signed [DW-1:0] a_exp_x, b_exp_x, diff_in, abs_diff;
    logic                 pass_a, pass_b, go;

    logic [FRAC_W-1:0] a_f;
    logic              a_s, b_s, sub_r, nr_r, shift_b;
    logic [1:0]        sm_r;
    logic [DW-1:0]     big_exp;
    logic [CW-1:0]     cnt;

    logic [FRAC_W-1:0] sh_val, sh_load_val, aligned, op_a, op_b, m_frac;
    logic              sh_ext_msb, sh_load, sh_step;
    logic              m_sign, m_carry, m_guard;

    // Start-time decode
    assign a_exp_x  = {a_exp[EXP_W-1], a_exp};
    assign b_exp_x  = {b_exp[EXP_W-1], b_exp};
    assign diff_in  = a_exp_x - b_exp_x;
    assign abs_diff = (diff_in < 0) ? -diff_in : diff_in;
    assign pass_b   = (a_frac == '0) || (diff_in < -WIN_S);
    assign pass_a   = !pass_b && ((b_frac == '0) || (diff_in > WIN_S));
    assign go       = (state == S_IDLE) && start;

    // Alignment shifter
    assign sh_load     = go && !pass_a && !pass_b;
    assign sh_load_val = (diff_in >= 0) ? b_frac : a_frac;
    assign sh_step     = (state == S_SHIFT);

    fpa_shifter #(.W(FRAC_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_load_val),
        .step(sh_step), .val(sh_val), .ext_msb(sh_ext_msb)
    );

    assign aligned = sh_val + {{(FRAC_W-1){1'b0}}, (~nr_r & sh_ext_msb)};
    assign op_a    = shift_b ? a_f : aligned;
    assign op_b    = shift_b ? aligned : sh_load_keep;

    logic [FRAC_W-1:0] sh_load_keep;  // unshifted B when A is the shifted one

    fpa_merge #(.W(FRAC_W)) u_merge (
        .a_mag(op_a), .b_mag(op_b), .a_sign(a_s),
        .eff_sub(a_s ^ b_s ^ sub_r), .no_round(nr_r),
        .m_frac(m_frac), .m_sign(m_sign), .m_carry(m_carry), .m_guard(m_guard)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) begin
                if (pass_a || pass_b)   state_nx = S_DONE;
                else if (abs_diff == 0) state_nx = S_MERGE;
                else                    state_nx = S_SHIFT;
            end
            S_SHIFT: if (cnt == CW'(1)) state_nx = S_MERGE;
            S_MERGE: state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
        endcase
    end

    // Operand capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_f <= '0; sh_load_keep <= '0;
            a_s <= 1'b0; b_s <= 1'b0; sub_r <= 1'b0; nr_r <= 1'b0;
            sm_r <= '0; shift_b <= 1'b0; big_exp <= '0; cnt <= '0;
            res_sign <= 1'b0; res_exp <= '0; res_frac <= '0; res_guard <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    a_f          <= a_frac;
                    sh_load_keep <= b_frac;
                    a_s          <= a_sign;
                    b_s          <= b_sign;
                    sub_r        <= sub_op;
                    nr_r         <= no_round;
                    sm_r         <= sgn_mod;
                    shift_b      <= (diff_in >= 0);
                    big_exp      <= (diff_in >= 0) ? a_exp_x : b_exp_x;
                    cnt          <= abs_diff[CW-1:0];
                    res_guard    <= 1'b0;
                    if (pass_b) begin
                        res_sign <= apply_sgn_mod(b_sign ^ sub_op, sgn_mod);
                        res_exp  <= b_exp_x;
                        res_frac <= b_frac;
                    end else if (pass_a) begin
                        res_sign <= apply_sgn_mod(a_sign, sgn_mod);
                        res_exp  <= a_exp_x;
                        res_frac <= a_frac;
                    end
                end
                S_SHIFT: cnt <= cnt - CW'(1);
                S_MERGE: begin
                    res_frac  <= m_frac;
                    res_sign  <= apply_sgn_mod(m_sign, sm_r);
                    res_guard <= m_guard;
                    res_exp   <= big_exp + {{(DW-1){1'b0}}, m_carry};
                end
                S_DONE: ;
            endcase
        end
    end

    assign res_valid = (state == S_DONE);

    // Checks
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R9
    AST_GUARD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !res_guard); // R9
    AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (pass_a || pass_b)) |=> res_valid); // R2
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && cnt > CW'(1)) |=> (state == S_SHIFT && cnt == $past(cnt) - CW'(1))); // R4
    AST_CARRY_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_guard) |-> res_frac[FRAC_W-1]); // R7
    AST_FORCED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (sm_r[1] ^ sm_r[0])) |-> (res_sign == sm_r[1])); // R8
endmodule

// File: tb/sim_fpa_align_add.sv
module sim_fpa_align_add;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic a_sign = 1'b0, b_sign = 1'b0, sub_op = 1'b0, no_round = 1'b0;
    logic [17:0] a_exp = '0, b_exp = '0;
    logic [34:0] a_frac = '0, b_frac = '0;
    logic [1:0]  sgn_mod = '0;
    logic        res_valid, res_sign, res_guard;
    logic [18:0] res_exp;
    logic [34:0] res_frac;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam longint FMASK = (64'sd1 <<< 35) - 1;
    localparam longint TOP   = 64'sd1 <<< 34;

    always #2.5 clk = ~clk;

    fpa_align_add u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
        .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
        .sub_op(sub_op), .no_round(no_round), .sgn_mod(sgn_mod),
        .res_valid(res_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_frac(res_frac), .res_guard(res_guard)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit smod(input bit s, input bit [1:0] m);
        case (m)
            2'b00: return s;
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            default: return ~s;
        endcase
    endfunction

    // Reference model built from the requirements
    task automatic model(input bit sa, input int ea, input longint fa,
                         input bit sb, input int eb, input longint fb,
                         input bit sub, input bit nr, input bit [1:0] sm,
                         output bit es, output int ee, output longint ef,
                         output bit eg, output int elat, output string tag);
        int d;
        longint x, y, s;
        d  = ea - eb;
        eg = 1'b0;
        if (fa == 0 || d < -35) begin
            es = sb ^ sub; ee = eb; ef = fb; elat = 1; tag = "R2";
        end else if (fb == 0 || d > 35) begin
            es = sa; ee = ea; ef = fa; elat = 1; tag = "R3";
        end else begin
            x = fa; y = fb; tag = "R4";
            if (d >= 0) begin
                ee = ea;
                if (d > 0) begin
                    y = fb >> d;
                    if (!nr && (((fb >> (d - 1)) & 1) == 1)) y++;
                end
            end else begin
                ee = eb;
                x = fa >> (-d);
                if (!nr && (((fa >> (-d - 1)) & 1) == 1)) x++;
            end
            elat = ((d < 0) ? -d : d) + 2;
            if (sa ^ sb ^ sub) begin
                tag = "R6";
                if (x >= y) begin ef = x - y; es = sa; end
                else        begin ef = y - x; es = ~sa; end
            end else begin
                s = x + y; es = sa;
                if (s > FMASK) begin
                    tag = "R7";
                    eg = bit'(s & 1);
                    s  = s >> 1;
                    ee = ee + 1;
                    if (!nr && eg) s++;
                end
                ef = s;
            end
        end
        es = smod(es, sm);
    endtask

    task automatic do_op(input bit sa, input int ea, input longint fa,
                         input bit sb, input int eb, input longint fb,
                         input bit sub, input bit nr, input bit [1:0] sm,
                         input string tag_o);
        bit es, eg;
        int ee, elat, lat;
        longint ef;
        string tag;
        model(sa, ea, fa, sb, eb, fb, sub, nr, sm, es, ee, ef, eg, elat, tag);
        if (tag_o != "") tag = tag_o;
        @(negedge clk);
        a_sign = sa; a_exp = 18'(ea); a_frac = 35'(fa);
        b_sign = sb; b_exp = 18'(eb); b_frac = 35'(fb);
        sub_op = sub; no_round = nr; sgn_mod = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!res_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(tag, "latency", lat, elat);
        chk(tag, "fraction", longint'(res_frac), ef);
        chk(tag, "sign", longint'(res_sign), longint'(es));
        chk(tag, "exponent", longint'(int'($signed(res_exp))), longint'(ee));
        chk(tag, "guard", longint'(res_guard), longint'(eg));
        @(negedge clk);
        chk("R9", "valid one cycle", longint'(res_valid), 0);
    endtask

    function automatic longint rfrac();
        longint v;
        v = longint'({$urandom(), $urandom()}) & FMASK;
        if (($urandom() & 15) == 0) v = 0;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "valid", longint'(res_valid), 0);
        chk("R1", "fraction", longint'(res_frac), 0);
        chk("R1", "exponent", longint'(res_exp), 0);
        chk("R1", "sign", longint'(res_sign), 0);
        chk("R1", "guard", longint'(res_guard), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero A, and B far larger
        do_op(0, 3, 0, 0, 7, 5, 1, 0, 2'b00, "R2");
        do_op(0, 0, 12345, 1, 36, 777, 0, 0, 2'b00, "R2");
        // R3: zero B, and A far larger
        do_op(1, 9, 4242, 0, 2, 0, 1, 0, 2'b00, "R3");
        do_op(0, 36, 999, 0, 0, 12345, 1, 0, 2'b00, "R3");
        // R4/R5: edge of the window, discarded top bit 1
        do_op(0, 35, TOP, 0, 0, TOP, 0, 0, 2'b00, "R5");
        do_op(0, 35, TOP, 0, 0, TOP, 0, 1, 2'b00, "R5");
        do_op(0, -5, TOP + 3, 0, 30, 100, 0, 0, 2'b00, "R5");
        do_op(0, 1, 1000, 0, 0, 3, 0, 0, 2'b00, "R5");
        do_op(0, 1, 1000, 0, 0, 3, 0, 1, 2'b00, "R5");
        // R6: equal magnitudes and B larger under subtraction
        do_op(1, 4, 5555, 1, 4, 5555, 1, 0, 2'b00, "R6");
        do_op(0, 4, 10, 0, 4, 30, 1, 0, 2'b00, "R6");
        do_op(0, 4, 10, 1, 4, 30, 0, 0, 2'b00, "R6");
        // R7: carry with LSB 1, with and without rounding
        do_op(0, 6, TOP + 1, 0, 6, TOP, 0, 0, 2'b00, "R7");
        do_op(0, 6, TOP + 1, 0, 6, TOP, 0, 1, 2'b00, "R7");
        do_op(1, 6, FMASK, 1, 6, FMASK, 0, 0, 2'b00, "R7");
        // R8: every sign-modify code
        for (int m = 0; m < 4; m++) begin
            do_op(1, 2, 600, 1, 1, 200, 0, 0, 2'(m), "R8");
            do_op(0, 2, 600, 0, 1, 200, 0, 0, 2'(m), "R8");
        end

        // Random mix around the window
        for (int i = 0; i < 400; i++) begin
            int ea, eb;
            ea = int'($urandom_range(0, 4000)) - 2000;
            eb = ea + int'($urandom_range(0, 84)) - 42;
            do_op(1'($urandom()), ea, rfrac(), 1'($urandom()), eb, rfrac(),
                  1'($urandom()), 1'($urandom()), 2'($urandom()), "");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual no completion expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule